// File: doc/BRIEF.md
# Byte and Word Data Memory Controller with Terminal Output Port

This block is the data memory port of a small 16-bit processor. The processor presents the address computed by its ALU, the store data, a write enable and a size select. The controller then stores or loads either a full 16-bit word or a single byte in an internal RAM. The RAM is byte addressed and little-endian. It is built as two 8-bit lanes, so a byte store changes only the lane it addresses.

All writes take effect on the falling clock edge, halfway through the processor cycle. This leaves the control lines a half cycle to settle after the rising edge before anything is committed. Reads are combinational from the current address.

One address, 0xFF10 by default, also drives a character terminal. Any enabled store to that address raises a terminal strobe for the cycle and presents the low seven bits of the store data as the character. The terminal samples both on the falling edge, as the RAM does. The same store still updates the RAM at the location that address maps to.

Top module: `mmctl_top`

## Requirements
- R1: A word store (mem_word=1) writes mem_wdata[7:0] to the byte at the even address {addr[WORD_AW:1],0} and mem_wdata[15:8] to the following odd byte. Address bit 0 is ignored for word accesses.
- R2: A byte store (mem_word=0) writes mem_wdata[7:0] into the single byte selected by mem_addr. The other byte of that word keeps its value.
- R3: A word load returns {byte at odd address, byte at even address} of the addressed word on mem_rdata.
- R4: A byte load returns the addressed byte in mem_rdata[7:0], with mem_rdata[15:8] forced to zero.
- R5: A store is committed on the falling clock edge. Before that edge, mem_rdata for the same address still shows the old contents. After that edge, it shows the new contents without waiting for a further rising edge.
- R6: term_stb is high exactly when mem_we is high, mem_addr equals TERM_ADDR (0xFF10), and the block is out of reset.
- R7: While term_stb is high, term_char equals mem_wdata[6:0].
- R8: A store to TERM_ADDR also updates the RAM word that the address maps to, as any other store would.
- R9: While rst_n is low, and for two rising edges after it goes high, stores change no RAM contents and term_stb stays low.
- R10: Only mem_addr[WORD_AW:0] (bits 8..0 by default) select RAM storage. Addresses that differ only in higher bits refer to the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; RAM and terminal commit on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | input | 16 | Byte address from the ALU |
| mem_wdata | input | 16 | Store data; byte stores use bits 7..0 |
| mem_we | input | 1 | Store enable |
| mem_word | input | 1 | Size select: 1 word, 0 byte |
| mem_rdata | output | 16 | Load data, zero-extended for byte loads |
| term_stb | output | 1 | Terminal write strobe for a store to TERM_ADDR |
| term_char | output | 7 | Character for the terminal, low seven bits of store data |

## Verification
Every word is first filled with a distinct pattern. A seeded random mix of byte and word loads and stores then runs over the full 16-bit address range, with roughly one access in eight aimed at the terminal address. A byte-level model checks each result, so a mistake in lane steering, endianness or zero extension produces a mismatch. Directed cases cover the following:
- an odd-lane byte store followed by a word load, which separates correct lane masking from a full-word write;
- a word store at an odd address, which tests that bit 0 is ignored;
- an access at an address offset by 512, which exposes wrong aliasing;
- a terminal store made during reset, which must leave both the strobe and the RAM untouched.

Reading the same address just before and just after the falling edge shows whether the write lands on the correct edge.

// File: rtl/mmctl_pkg.sv
`timescale 1ns/1ps
package mmctl_pkg;
  localparam int DATA_W  = 16;
  localparam int LANE_W  = 8;
  localparam int N_LANES = DATA_W / LANE_W;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } size_e;

  typedef struct packed {
    logic [N_LANES-1:0]  lane_we;
    logic [DATA_W-1:0]   lane_d;
  } wr_req_t;
endpackage

// File: rtl/mmctl_rst_sync.sv
`timescale 1ns/1ps
module mmctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic run_q
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run_q = sync_q[1];
endmodule

// File: rtl/mmctl_wr_decode.sv
`timescale 1ns/1ps
module mmctl_wr_decode
  import mmctl_pkg::*;
(
  input  logic              addr_lsb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  size_e             size,
  input  logic              run,
  output wr_req_t           req
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic hit;
    always_comb begin
      hit = (size == SZ_WORD) || (addr_lsb == l[0]);
      req.lane_we[l] = we && run && hit;
      if (size == SZ_WORD) req.lane_d[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
      else                 req.lane_d[l*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/mmctl_lane_ram.sv
`timescale 1ns/1ps
module mmctl_lane_ram #(
  parameter int AW = 8,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [W-1:0]  d,
  output logic [W-1:0]  q
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(negedge clk) begin
    if (we) mem[idx] <= d;
  end

  assign q = mem[idx];
endmodule

// File: rtl/mmctl_rd_align.sv
`timescale 1ns/1ps
module mmctl_rd_align
  import mmctl_pkg::*;
(
  input  logic              addr_lsb,
  input  size_e             size,
  input  logic [DATA_W-1:0] word_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    if (size == SZ_WORD)  rdata = word_q;
    else if (addr_lsb)    rdata = {{(DATA_W-LANE_W){1'b0}}, word_q[DATA_W-1 -: LANE_W]};
    else                  rdata = {{(DATA_W-LANE_W){1'b0}}, word_q[LANE_W-1:0]};
  end
endmodule

// File: rtl/mmctl_top.sv
`timescale 1ns/1ps
module mmctl_top
  import mmctl_pkg::*;
#(
  parameter int          WORD_AW   = 8,
  parameter logic [15:0] TERM_ADDR = 16'hFF10,
  parameter int          CHAR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       mem_addr,
  input  logic [15:0]       mem_wdata,
  input  logic              mem_we,
  input  logic              mem_word,
  output logic [15:0]       mem_rdata,
  output logic              term_stb,
  output logic [CHAR_W-1:0] term_char
);
  logic              run_q;
  size_e             size;
  wr_req_t           req;
  logic [WORD_AW-1:0] word_idx;
  logic [DATA_W-1:0] word_q;

  assign size     = mem_word ? SZ_WORD : SZ_BYTE;
  assign word_idx = mem_addr[WORD_AW:1];

  mmctl_rst_sync i_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run_q (run_q)
  );

  mmctl_wr_decode i_wr_decode (
    .addr_lsb (mem_addr[0]),
    .wdata    (mem_wdata),
    .we       (mem_we),
    .size     (size),
    .run      (run_q),
    .req      (req)
  );

  for (genvar l = 0; l < N_LANES; l++) begin : g_ram
    mmctl_lane_ram #(.AW(WORD_AW), .W(LANE_W)) i_lane (
      .clk (clk),
      .we  (req.lane_we[l]),
      .idx (word_idx),
      .d   (req.lane_d[l*LANE_W +: LANE_W]),
      .q   (word_q[l*LANE_W +: LANE_W])
    );
  end

  mmctl_rd_align i_rd_align (
    .addr_lsb (mem_addr[0]),
    .size     (size),
    .word_q   (word_q),
    .rdata    (mem_rdata)
  );

  assign term_stb  = run_q && mem_we && (mem_addr == TERM_ADDR);
  assign term_char = mem_wdata[CHAR_W-1:0];
endmodule

// File: rtl/mmctl_chk.sv
`timescale 1ns/1ps
module mmctl_chk #(
  parameter logic [15:0] TERM_ADDR = 16'hFF10,
  parameter int          CHAR_W    = 7
) (
  input logic              clk,
  input logic              run_q,
  input logic [15:0]       mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              mem_we,
  input logic              mem_word,
  input logic [15:0]       mem_rdata,
  input logic              term_stb,
  input logic [CHAR_W-1:0] term_char
);
  assert_word_readback_R1: assert property (@(posedge clk) disable iff (!run_q)
    (mem_we && mem_word && $past(run_q)) |-> (mem_rdata == mem_wdata));

  assert_byte_readback_R2: assert property (@(posedge clk) disable iff (!run_q)
    (mem_we && !mem_word && $past(run_q)) |-> (mem_rdata == {8'h00, mem_wdata[7:0]}));

  assert_byte_zext_R4: assert property (@(posedge clk) disable iff (!run_q)
    (!mem_word) |-> (mem_rdata[15:8] == 8'h00));

  assert_stb_needs_store_R6: assert property (@(posedge clk) disable iff (!run_q)
    term_stb |-> (mem_we && mem_addr == TERM_ADDR));

  assert_stb_on_store_R6: assert property (@(posedge clk) disable iff (!run_q)
    (mem_we && mem_addr == TERM_ADDR) |-> term_stb);

  assert_char_R7: assert property (@(posedge clk) disable iff (!run_q)
    term_stb |-> (term_char == mem_wdata[CHAR_W-1:0]));

  always_comb begin
    if (!run_q) begin
      assert_no_stb_in_reset_R9: assert (!term_stb);
    end
  end
endmodule

bind mmctl_top mmctl_chk #(.TERM_ADDR(TERM_ADDR), .CHAR_W(CHAR_W)) i_mmctl_chk (
  .clk       (clk),
  .run_q     (run_q),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we),
  .mem_word  (mem_word),
  .mem_rdata (mem_rdata),
  .term_stb  (term_stb),
  .term_char (term_char)
);

// File: tb/test_mmctl_top.sv
`timescale 1ns/1ps
module test_mmctl_top;
  localparam logic [15:0] TERM = 16'hFF10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        mem_word;
  logic [15:0] mem_rdata;
  logic        term_stb;
  logic [6:0]  term_char;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [512];

  always #2.5 clk = ~clk;

  mmctl_top i_mmctl_top (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_word(mem_word), .mem_rdata(mem_rdata),
    .term_stb(term_stb), .term_char(term_char)
  );

  function automatic logic [15:0] exp_load(input logic [15:0] a, input logic w);
    logic [8:0] b = a[8:0];
    if (w) return {model[{b[8:1], 1'b1}], model[{b[8:1], 1'b0}]};
    return {8'h00, model[b]};
  endfunction

  task automatic model_store(input logic [15:0] a, input logic w, input logic [15:0] d);
    logic [8:0] b = a[8:0];
    if (w) begin
      model[{b[8:1], 1'b0}] = d[7:0];
      model[{b[8:1], 1'b1}] = d[15:8];
    end else begin
      model[b] = d[7:0];
    end
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic op(input logic we, input logic w, input logic [15:0] a, input logic [15:0] d);
    logic [15:0] old;
    @(posedge clk); #1;
    mem_we = we; mem_word = w; mem_addr = a; mem_wdata = d;
    #0.5;
    old = exp_load(a, w);
    if (we) chk("R5 old data before falling edge", mem_rdata, old);
    else    chk(w ? "R3 word load" : "R4 byte load", mem_rdata, old);
    chk("R6 terminal strobe", {15'b0, term_stb}, {15'b0, we && a == TERM});
    if (term_stb) chk("R7 terminal char", {9'b0, term_char}, {9'b0, d[6:0]});
    if (we) begin
      model_store(a, w, d);
      @(negedge clk); #0.5;
      chk(w ? "R1 word store R5" : "R2 byte store R5", mem_rdata, exp_load(a, w));
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20191115));
    rst_n = 1'b0; mem_we = 1'b1; mem_word = 1'b1; mem_addr = TERM; mem_wdata = 16'h0041;
    #1;
    chk("R9 reset strobe low", {15'b0, term_stb}, 16'h0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; mem_we = 1'b0;
    repeat (3) @(posedge clk);

    for (int i = 0; i < 256; i++) begin
      op(1'b1, 1'b1, 16'(i * 2), 16'(i * 16'h0101) ^ 16'h5A3C);
    end

    // R2: odd-lane byte store, then word load shows lower byte untouched
    op(1'b1, 1'b0, 16'h0021, 16'h77C3);
    op(1'b0, 1'b1, 16'h0020, 16'h0000);
    // R2: even-lane byte store
    op(1'b1, 1'b0, 16'h0040, 16'hFF11);
    op(1'b0, 1'b1, 16'h0041, 16'h0000);
    // R1: word store at odd address ignores bit 0
    op(1'b1, 1'b1, 16'h0063, 16'hBEEF);
    op(1'b0, 1'b1, 16'h0062, 16'h0000);
    op(1'b0, 1'b0, 16'h0062, 16'h0000);
    op(1'b0, 1'b0, 16'h0063, 16'h0000);
    // R10: aliasing across 512 bytes
    op(1'b1, 1'b1, 16'h1234, 16'hCAFE);
    op(1'b0, 1'b1, 16'h1434, 16'h0000);
    op(1'b0, 1'b1, 16'h0034, 16'h0000);
    // R8 / R6 / R7: terminal store also hits RAM
    op(1'b1, 1'b0, TERM, 16'h00C8);
    op(1'b1, 1'b1, TERM, 16'h1265);
    op(1'b0, 1'b1, TERM, 16'h0000);
    op(1'b0, 1'b1, 16'h0110, 16'h0000);
    // R6: load at terminal address, store next to it
    op(1'b0, 1'b0, TERM, 16'h0000);
    op(1'b1, 1'b1, TERM + 16'd2, 16'h4444);

    // R9: store during reset is ignored
    @(posedge clk); #1;
    rst_n = 1'b0;
    mem_we = 1'b1; mem_word = 1'b1; mem_addr = TERM; mem_wdata = 16'hABCD;
    #0.5;
    chk("R9 strobe low in reset", {15'b0, term_stb}, 16'h0);
    @(negedge clk); @(posedge clk); #1;
    mem_we = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    op(1'b0, 1'b1, TERM, 16'h0000);

    for (int n = 0; n < 600; n++) begin
      logic [15:0] a = 16'($urandom);
      if ($urandom % 8 == 0) a = TERM;
      op(1'($urandom), 1'($urandom), a, 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule